// File: doc/BRIEF.md
# Segment-Tagged Translation Cache

This block keeps a small, fully associative set of recently used address translations. Each entry is keyed by a segment number joined to a virtual page number. A lookup presents a segment, a page number, a page offset and an access kind (read or write). In the same cycle the block reports one of three results: a hit with the physical address, a miss, or a protection fault. On a hit the physical address is the cached frame number with the offset placed below it.

On a miss, an external table walker fetches the translation and writes it through the fill port. The fill goes to an entry chosen in this order: the entry that already holds the same key, then the lowest-numbered empty entry, then the entry named by a round-robin eviction pointer. A flush input empties the whole cache in one cycle, for use on a context switch.

Top module: `seg_tlb`

## Requirements
- R1: When a lookup with `lk_valid` high matches a valid entry and the access is permitted, `lk_hit` is high in the same cycle and `lk_paddr` equals the entry's frame number in the upper `PPN_W` bits, with `lk_ofs` in the lower `OFS_W` bits.
- R2: When a lookup with `lk_valid` high matches no valid entry, `lk_miss` is high, `lk_hit` and `lk_fault` are low, and `lk_paddr` is zero.
- R3: The match key is the segment and the page number taken together. An entry with the same page number but a different segment does not match.
- R4: After a fill is accepted on a rising edge, a lookup of the filled key in the following cycle hits and returns the filled frame number.
- R5: A read lookup needs the entry's read permission (`fill_rd`). A write lookup (`lk_write`=1) needs its write permission (`fill_wr`). A matching lookup without the needed permission raises `lk_fault` with `lk_hit` and `lk_miss` low.
- R6: While any entry is empty, a fill of a new key goes to the lowest-numbered empty entry and evicts nothing. Filling up to `ENTRIES` distinct keys keeps every one of them resident.
- R7: When the cache is full, a fill of a new key replaces the entry at the eviction pointer, which then steps to the next index and wraps after `ENTRIES-1`. The pointer is zero after reset and moves only on such an eviction.
- R8: A fill whose key matches a valid entry overwrites that entry's frame number and permissions. It creates no second copy and does not move the eviction pointer.
- R9: A flush empties every entry, so all lookups in the next cycle miss. A fill in the same cycle as a flush is dropped.
- R10: After reset, every entry is empty.
- R11: While `lk_valid` is low, `lk_hit`, `lk_miss` and `lk_fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is a write (1) or a read (0) |
| lk_seg | input | SEG_W | Lookup segment number |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_ofs | input | OFS_W | Lookup page offset |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No valid entry holds the key |
| lk_fault | output | 1 | Key found but access not permitted |
| lk_paddr | output | PPN_W+OFS_W | Physical address on hit, zero otherwise |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_seg | input | SEG_W | Fill segment number |
| fill_vpn | input | VPN_W | Fill virtual page number |
| fill_ppn | input | PPN_W | Fill physical frame number |
| fill_rd | input | 1 | Fill read permission |
| fill_wr | input | 1 | Fill write permission |
| flush | input | 1 | Empty all entries |

## Verification
The bench uses a four-entry cache so that replacement can be observed through lookups. It fills the cache, then evicts twice and checks that the oldest two keys are gone in index order. A design that evicted before using empty entries, or that let the pointer drift, would drop a different key. It refills a resident key with a new frame number and then forces one more eviction. A design that made a duplicate, or advanced the pointer on a refill, would lose the wrong key or return the stale frame. Other cases check that a key with the same page number but another segment misses, that a read-only entry faults on a write and a write-only entry faults on a read, and that a fill arriving together with a flush does not survive.

// File: rtl/seg_tlb_pkg.sv
package seg_tlb_pkg;
   typedef struct packed {
      logic rd;
      logic wr;
   } perm_t;

   function automatic logic perm_ok(perm_t p, logic is_write);
      return is_write ? p.wr : p.rd;
   endfunction
endpackage

// File: rtl/seg_tlb_first_one.sv
module seg_tlb_first_one #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/seg_tlb_store.sv
module seg_tlb_store
   import seg_tlb_pkg::*;
#(
   parameter int TAG_W   = 12,
   parameter int PPN_W   = 12,
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  perm_t              wr_perm,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic [ENTRIES-1:0] lk_match,
   output logic [ENTRIES-1:0] fl_match,
   output logic [ENTRIES-1:0] valid_vec,
   output logic [PPN_W-1:0]   hit_ppn,
   output perm_t              hit_perm
);
   logic [PPN_W-1:0] ppn_arr  [ENTRIES];
   perm_t            perm_arr [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] tag_q;
      logic [PPN_W-1:0] ppn_q;
      perm_t            perm_q;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            tag_q  <= '0;
            ppn_q  <= '0;
            perm_q <= '0;
         end else if (flush) begin
            v_q <= 1'b0;
         end else if (sel) begin
            v_q    <= 1'b1;
            tag_q  <= wr_tag;
            ppn_q  <= wr_ppn;
            perm_q <= wr_perm;
         end
      end

      assign valid_vec[i] = v_q;
      assign lk_match[i]  = v_q && (tag_q == lk_tag);
      assign fl_match[i]  = v_q && (tag_q == wr_tag);
      assign ppn_arr[i]   = ppn_q;
      assign perm_arr[i]  = perm_q;
   end

   // Keys are unique, so at most one match bit is set and an OR of masked
   // entries selects it without a priority chain.
   always_comb begin
      hit_ppn  = '0;
      hit_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         hit_ppn  = hit_ppn  | (ppn_arr[i]  & {PPN_W{lk_match[i]}});
         hit_perm = hit_perm | (perm_arr[i] & {2{lk_match[i]}});
      end
   end
endmodule

// File: rtl/seg_tlb_victim.sv
module seg_tlb_victim #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_en,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] fl_match,
   output logic [IDX_W-1:0]   wr_idx
);
   localparam bit POW2 = (ENTRIES == (1 << IDX_W));

   logic [IDX_W-1:0] match_idx, free_idx, ptr_q, ptr_nxt;
   logic             match_any, free_any, evict;

   seg_tlb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_match (
      .vec(fl_match), .idx(match_idx), .any(match_any));

   seg_tlb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
      .vec(~valid_vec), .idx(free_idx), .any(free_any));

   always_comb begin
      if (match_any)     wr_idx = match_idx;
      else if (free_any) wr_idx = free_idx;
      else               wr_idx = ptr_q;
   end

   assign evict = fill_en && !match_any && !free_any;

   if (POW2) begin : g_wrap_free
      assign ptr_nxt = ptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nxt = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '0;
      else if (evict) ptr_q <= ptr_nxt;
   end
endmodule

// File: rtl/seg_tlb.sv
module seg_tlb
   import seg_tlb_pkg::*;
#(
   parameter int SEG_W   = 4,
   parameter int VPN_W   = 8,
   parameter int OFS_W   = 12,
   parameter int PPN_W   = 12,
   parameter int ENTRIES = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lk_valid,
   input  logic                   lk_write,
   input  logic [SEG_W-1:0]       lk_seg,
   input  logic [VPN_W-1:0]       lk_vpn,
   input  logic [OFS_W-1:0]       lk_ofs,
   output logic                   lk_hit,
   output logic                   lk_miss,
   output logic                   lk_fault,
   output logic [PPN_W+OFS_W-1:0] lk_paddr,
   input  logic                   fill_valid,
   input  logic [SEG_W-1:0]       fill_seg,
   input  logic [VPN_W-1:0]       fill_vpn,
   input  logic [PPN_W-1:0]       fill_ppn,
   input  logic                   fill_rd,
   input  logic                   fill_wr,
   input  logic                   flush
);
   localparam int TAG_W = SEG_W + VPN_W;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int PA_W  = PPN_W + OFS_W;

   if (ENTRIES < 2)   begin : g_chk_ent  $error("seg_tlb: ENTRIES must be at least 2"); end
   if (SEG_W < 1)     begin : g_chk_seg  $error("seg_tlb: SEG_W must be positive"); end
   if (VPN_W < 1)     begin : g_chk_vpn  $error("seg_tlb: VPN_W must be positive"); end
   if (PPN_W < 1)     begin : g_chk_ppn  $error("seg_tlb: PPN_W must be positive"); end
   if (OFS_W < 1)     begin : g_chk_ofs  $error("seg_tlb: OFS_W must be positive"); end

   logic [TAG_W-1:0]   lk_tag, fl_tag;
   logic [ENTRIES-1:0] lk_match, fl_match, valid_vec;
   logic [PPN_W-1:0]   hit_ppn;
   perm_t              hit_perm, fl_perm;
   logic [IDX_W-1:0]   wr_idx;
   logic               fill_en, present, allowed;

   assign lk_tag  = {lk_seg, lk_vpn};
   assign fl_tag  = {fill_seg, fill_vpn};
   assign fl_perm = '{rd: fill_rd, wr: fill_wr};
   assign fill_en = fill_valid && !flush;

   seg_tlb_store #(
      .TAG_W(TAG_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (fill_en),
      .wr_idx   (wr_idx),
      .wr_tag   (fl_tag),
      .wr_ppn   (fill_ppn),
      .wr_perm  (fl_perm),
      .lk_tag   (lk_tag),
      .lk_match (lk_match),
      .fl_match (fl_match),
      .valid_vec(valid_vec),
      .hit_ppn  (hit_ppn),
      .hit_perm (hit_perm)
   );

   seg_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_en  (fill_en),
      .valid_vec(valid_vec),
      .fl_match (fl_match),
      .wr_idx   (wr_idx)
   );

   assign present  = |lk_match;
   assign allowed  = perm_ok(hit_perm, lk_write);
   assign lk_hit   = lk_valid && present && allowed;
   assign lk_fault = lk_valid && present && !allowed;
   assign lk_miss  = lk_valid && !present;
   assign lk_paddr = lk_hit ? {hit_ppn, lk_ofs} : PA_W'(0);
endmodule

// File: rtl/seg_tlb_checker.sv
module seg_tlb_checker #(
   parameter int ENTRIES = 64,
   parameter int OFS_W   = 12,
   parameter int PA_W    = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [OFS_W-1:0]   lk_ofs,
   input logic               lk_hit,
   input logic               lk_miss,
   input logic               lk_fault,
   input logic [PA_W-1:0]    lk_paddr,
   input logic               flush,
   input logic [ENTRIES-1:0] lk_match,
   input logic [ENTRIES-1:0] valid_vec
);
   p_one_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

   p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> lk_paddr == '0);

   p_hit_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_paddr[OFS_W-1:0] == lk_ofs);

   p_unique_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> valid_vec == '0);
endmodule

bind seg_tlb seg_tlb_checker #(
   .ENTRIES(ENTRIES), .OFS_W(OFS_W), .PA_W(PPN_W + OFS_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_valid (lk_valid),
   .lk_ofs   (lk_ofs),
   .lk_hit   (lk_hit),
   .lk_miss  (lk_miss),
   .lk_fault (lk_fault),
   .lk_paddr (lk_paddr),
   .flush    (flush),
   .lk_match (lk_match),
   .valid_vec(valid_vec)
);

// File: tb/seg_tlb_test.sv
module seg_tlb_test;
   localparam int SEG_W = 4, VPN_W = 8, OFS_W = 12, PPN_W = 12, ENTRIES = 4;
   localparam int PA_W = PPN_W + OFS_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_valid = 1'b0, lk_write = 1'b0;
   logic [SEG_W-1:0] lk_seg = '0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic [OFS_W-1:0] lk_ofs = '0;
   logic             lk_hit, lk_miss, lk_fault;
   logic [PA_W-1:0]  lk_paddr;
   logic             fill_valid = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, flush = 1'b0;
   logic [SEG_W-1:0] fill_seg = '0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PPN_W-1:0] fill_ppn = '0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   seg_tlb #(.SEG_W(SEG_W), .VPN_W(VPN_W), .OFS_W(OFS_W), .PPN_W(PPN_W),
             .ENTRIES(ENTRIES)) uut (.*);

   localparam int K_HIT = 0, K_MISS = 1, K_FAULT = 2;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic probe(input logic [SEG_W-1:0] s, input logic [VPN_W-1:0] v,
                        input logic [OFS_W-1:0] o, input logic wr, input int kind,
                        input logic [PPN_W-1:0] ppn, input string req);
      logic [26:0] got, exp;
      @(negedge clk);
      lk_valid = 1'b1; lk_write = wr; lk_seg = s; lk_vpn = v; lk_ofs = o;
      #1;
      got = {lk_hit, lk_miss, lk_fault, lk_paddr};
      exp = {kind == K_HIT, kind == K_MISS, kind == K_FAULT,
             (kind == K_HIT) ? {ppn, o} : PA_W'(0)};
      check(got == exp, req, 32'(got), 32'(exp));
      lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [SEG_W-1:0] s, input logic [VPN_W-1:0] v,
                       input logic [PPN_W-1:0] p, input logic r, input logic w,
                       input logic with_flush);
      @(negedge clk);
      fill_valid = 1'b1; fill_seg = s; fill_vpn = v; fill_ppn = p;
      fill_rd = r; fill_wr = w; flush = with_flush;
      @(negedge clk);
      fill_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      check({lk_hit, lk_miss, lk_fault} == 3'b000, "R11 idle flags",
            32'({lk_hit, lk_miss, lk_fault}), 0);
      probe(4'd0, 8'd0, 12'h000, 1'b0, K_MISS, '0, "R10 empty after reset");
      probe(4'd1, 8'h10, 12'h123, 1'b0, K_MISS, '0, "R2 miss on unknown key");
   endtask

   task automatic t_fill_hit();
      fill(4'd1, 8'h10, 12'hABC, 1'b1, 1'b1, 1'b0);
      probe(4'd1, 8'h10, 12'h123, 1'b0, K_HIT, 12'hABC, "R4 hit after fill");
      probe(4'd1, 8'h10, 12'hFFF, 1'b1, K_HIT, 12'hABC, "R1 paddr with offset");
      probe(4'd1, 8'h10, 12'h000, 1'b0, K_HIT, 12'hABC, "R1 zero offset");
   endtask

   task automatic t_seg_tag();
      probe(4'd2, 8'h10, 12'h010, 1'b0, K_MISS, '0, "R3 other segment misses");
      probe(4'd1, 8'h11, 12'h010, 1'b0, K_MISS, '0, "R3 other page misses");
   endtask

   task automatic t_perm();
      fill(4'd3, 8'h20, 12'h321, 1'b1, 1'b0, 1'b0);
      probe(4'd3, 8'h20, 12'h004, 1'b1, K_FAULT, '0, "R5 write to read-only");
      probe(4'd3, 8'h20, 12'h004, 1'b0, K_HIT, 12'h321, "R5 read of read-only");
      fill(4'd3, 8'h21, 12'h654, 1'b0, 1'b1, 1'b0);
      probe(4'd3, 8'h21, 12'h008, 1'b0, K_FAULT, '0, "R5 read of write-only");
      probe(4'd3, 8'h21, 12'h008, 1'b1, K_HIT, 12'h654, "R5 write to write-only");
   endtask

   task automatic t_fill_order();
      do_flush();
      for (int k = 0; k < 4; k++)
         fill(4'd5, 8'(8'h40 + k), 12'(12'h100 + k), 1'b1, 1'b1, 1'b0);
      for (int k = 0; k < 4; k++)
         probe(4'd5, 8'(8'h40 + k), 12'h0AA, 1'b0, K_HIT, 12'(12'h100 + k),
               "R6 all four resident");
   endtask

   task automatic t_round_robin();
      fill(4'd6, 8'h40, 12'h200, 1'b1, 1'b1, 1'b0);
      probe(4'd5, 8'h40, 12'h001, 1'b0, K_MISS, '0, "R7 index 0 evicted first");
      probe(4'd5, 8'h41, 12'h001, 1'b0, K_HIT, 12'h101, "R7 index 1 kept");
      fill(4'd6, 8'h41, 12'h201, 1'b1, 1'b1, 1'b0);
      probe(4'd5, 8'h41, 12'h001, 1'b0, K_MISS, '0, "R7 index 1 evicted next");
      probe(4'd6, 8'h40, 12'h001, 1'b0, K_HIT, 12'h200, "R7 new entry resident");
   endtask

   task automatic t_overwrite();
      fill(4'd5, 8'h43, 12'h3FF, 1'b1, 1'b1, 1'b0);
      probe(4'd5, 8'h43, 12'h077, 1'b0, K_HIT, 12'h3FF, "R8 refill updates frame");
      probe(4'd5, 8'h42, 12'h077, 1'b0, K_HIT, 12'h102, "R8 refill evicts nothing");
      fill(4'd7, 8'h01, 12'h2A5, 1'b1, 1'b1, 1'b0);
      probe(4'd5, 8'h42, 12'h077, 1'b0, K_MISS, '0, "R8 pointer unmoved by refill");
      probe(4'd5, 8'h43, 12'h077, 1'b0, K_HIT, 12'h3FF, "R8 refilled entry kept");
      probe(4'd7, 8'h01, 12'h077, 1'b0, K_HIT, 12'h2A5, "R8 new entry resident");
   endtask

   task automatic t_flush();
      do_flush();
      probe(4'd6, 8'h40, 12'h000, 1'b0, K_MISS, '0, "R9 flushed entry misses");
      probe(4'd7, 8'h01, 12'h000, 1'b0, K_MISS, '0, "R9 flushed entry misses");
      fill(4'd8, 8'h08, 12'h088, 1'b1, 1'b1, 1'b1);
      probe(4'd8, 8'h08, 12'h000, 1'b0, K_MISS, '0, "R9 fill during flush dropped");
      // pointer now 3: empty entries must fill first, then index 3 goes
      for (int k = 0; k < 4; k++)
         fill(4'd9, 8'(k), 12'(12'h500 + k), 1'b1, 1'b1, 1'b0);
      fill(4'd9, 8'd4, 12'h504, 1'b1, 1'b1, 1'b0);
      probe(4'd9, 8'd3, 12'h000, 1'b0, K_MISS, '0, "R7 eviction at held pointer");
      probe(4'd9, 8'd0, 12'h000, 1'b0, K_HIT, 12'h500, "R6 empty slot used first");
      probe(4'd9, 8'd4, 12'h000, 1'b0, K_HIT, 12'h504, "R4 latest fill hits");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill_hit();
      t_seg_tag();
      t_perm();
      t_fill_order();
      t_round_robin();
      t_overwrite();
      t_flush();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule